// File: doc/BRIEF.md
# Indexed Strobe Data Port

This block is an I/O slave on an ISA-style host bus. It serves a small set of sockets, two by default. The host sees only two ports. It first writes an index at the index port. The data port then opens a window that the index selects. For each socket, two index values matter. One reaches that socket's extended index register. The other reaches the register that the extended index points at. That register is either the socket's strobe control register or its external data register.

When a socket's external data register is selected and the host reads or writes the data port, the block drives that socket's general-purpose strobe pin. The strobe is active for exactly as long as the host read or write pulse is low, so it can clock an external latch or enable an external buffer. Software sets three things for each socket: the strobe's active level, whether reads, writes or both fire the strobe, and whether the pin is push-pull or open-drain. The pin is modelled as a value plus an output enable.

A shadow of the external data register lets software read back what it wrote to a write-only latch. When neither strobe direction is enabled, the pin is treated as an input and its pull-up is turned on. The pull-up stays off while the pin is a strobe, or when that socket's pull-up disable input is high.

Top module: `xdata_strobe_port`

## Requirements
- R1: After reset, the index, every extended index, every strobe control and every external data register read 0. No strobe pin is driven (`strb_oe` = 0, `strb_out` = 0) and every pull-up is enabled (`strb_pu` = 1).
- R2: A write to the index port (0x3E0) stores `io_wdata[7:0]` in the index register, and the upper byte is ignored. A read of the index port returns the index on `io_rdata[7:0]` with the upper bits 0.
- R3: With the index at 0x40·s+0x2E, the data port (0x3E1) writes and reads socket s's 8-bit extended index on byte lane [7:0].
- R4: With the index at 0x40·s+0x2F and the extended index at 0x0C, the data port reaches socket s's strobe control register. Only bits 5:2 are stored. Bits 7:6 and 1:0 always read 0.
- R5: When control bit 4 (write strobe) is set, the index is 0x40·s+0x2F and the extended index is 0x0A, a data-port write makes socket s's strobe active in the same cycles that `iow_n` is low. Other sockets' strobes stay inactive.
- R6: When control bit 3 (read strobe) is set, under the same selection, a data-port read makes the strobe active in the same cycles that `ior_n` is low.
- R7: No strobe fires when the index or the extended index does not select the external data register, or when the direction bit that matches the cycle is clear.
- R8: Control bit 5 clear: the strobe is active-low and idles high. Control bit 5 set: the strobe idles low and is high while active.
- R9: Control bit 2 set (push-pull): `strb_oe` = 1 and `strb_out` follows the pin level. Control bit 2 clear (open-drain): `strb_out` = 0 and `strb_oe` = 1 only while the level is low.
- R10: `strb_pu[s]` = 1 exactly when control bits 3 and 4 are both clear and `pu_off[s]` = 0. `strb_oe[s]` = 0 whenever neither direction bit is set.
- R11: The external data register is 8 bits, resets to 0 and is written by data-port writes while it is selected. A read of it returns the stored (shadow) value if control bit 4 is set or if neither direction bit is set. It returns `ext_rdata` for the socket if only bit 3 is set.
- R12: External data uses byte lane [15:8] when `DBUS_W` is 16 and lane [7:0] when it is 8. All other registers use lane [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_wdata | input | DBUS_W | Host write data |
| iow_n | input | 1 | Host I/O write pulse, active low |
| ior_n | input | 1 | Host I/O read pulse, active low |
| io_rdata | output | DBUS_W | Read data, 0 when no register is being read |
| ext_rdata | input | NSOCK*8 | Data from each socket's external buffer, socket s at [8s+7:8s] |
| pu_off | input | NSOCK | Per-socket pull-up disable |
| strb_out | output | NSOCK | Strobe pin value driven when enabled |
| strb_oe | output | NSOCK | Strobe pin output enable |
| strb_pu | output | NSOCK | Strobe pin pull-up enable |

## Verification
Strobe pins, output enables, pull-ups and read data follow the current `iow_n`, `ior_n` and `io_addr` in the same cycle, with no register in between. Register contents change at the first rising clock edge that sees `iow_n` low at a decoded port, and become visible from the next cycle onward. The bench drives inputs one nanosecond after a rising edge and samples on the falling edge. A check taken during a pulse therefore sees that pulse's strobe and the register state from before its commit edge. A check taken after the pulse sees the committed value. A behavioural model advances on the same rising edges and is compared against every output on every falling edge.

// File: rtl/xds_pkg.sv
// Package: shared constants and the strobe control layout for the indexed
// strobe data port. Assumes 8-bit index and extended index registers.
package xds_pkg;

    // extended index values inside a socket's data window
    localparam logic [7:0] XI_DATA     = 8'h0A;
    localparam logic [7:0] XI_CTRL     = 8'h0C;

    // per-socket index offsets; socket s adds s * SOCK_STRIDE
    localparam logic [7:0] WIN_XIDX    = 8'h2E;
    localparam logic [7:0] WIN_XDAT    = 8'h2F;
    localparam int         SOCK_STRIDE = 64;

    // writable bits of the strobe control register
    localparam logic [7:0] CTRL_MASK   = 8'h3C;

    typedef struct packed {
        logic [1:0] rsv_hi;
        logic       pol_hi;     // 1: strobe high while active
        logic       wr_en;      // write cycles fire the strobe
        logic       rd_en;      // read cycles fire the strobe
        logic       push_pull;  // 1: drive both levels
        logic [1:0] rsv_lo;
    } ctrl_t;

endpackage

// File: rtl/xds_pin.sv
// Module: converts a socket's logical strobe state into pin value, output
// enable and pull-up enable. Assumes the caller resolves strobe activity.
module xds_pin (
    input  logic act,
    input  logic pol_hi,
    input  logic mode_en,
    input  logic push_pull,
    input  logic pu_off,
    output logic pin_out,
    output logic pin_oe,
    output logic pin_pu
);
    logic lvl;

    // pin drive, enable and pull-up from level and drive mode
    always_comb begin
        lvl     = pol_hi ? act : ~act;
        pin_oe  = mode_en & (push_pull | ~lvl);
        pin_out = mode_en & push_pull & lvl;
        pin_pu  = ~mode_en & ~pu_off;
    end
endmodule

// File: rtl/xds_sock.sv
// Module: one socket's extended index, strobe control and external data
// (shadow) registers, its strobe decode and read mux. Assumes the top
// qualifies dat_wr/dat_rd with the data-port address.
module xds_sock
    import xds_pkg::*;
#(
    parameter int SOCK   = 0,
    parameter int DBUS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic [7:0]        idx_q,
    input  logic [DBUS_W-1:0] wdata,
    input  logic [7:0]        ext_in,
    input  logic              pu_off,
    output logic [DBUS_W-1:0] rdata,
    output logic              strb_act,
    output logic [7:0]        ctrl_o,
    output logic [7:0]        data_o,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              pin_pu
);
    localparam int         LANE  = (DBUS_W >= 16) ? 8 : 0;
    localparam logic [7:0] BASE  = 8'(SOCK * SOCK_STRIDE);
    localparam logic [7:0] IX_X  = BASE + WIN_XIDX;
    localparam logic [7:0] IX_D  = BASE + WIN_XDAT;

    logic [7:0] xidx_q;
    ctrl_t      ctrl_q;
    logic [7:0] data_q;
    logic       sel_x, sel_d, sel_ext;

    // window selection from the shared index and own extended index
    always_comb begin
        sel_x   = (idx_q == IX_X);
        sel_d   = (idx_q == IX_D);
        sel_ext = sel_d && (xidx_q == XI_DATA);
    end

    // register writes, captured on every edge the write pulse is low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xidx_q <= '0;
            ctrl_q <= '0;
            data_q <= '0;
        end else if (dat_wr) begin
            if (sel_x) begin
                xidx_q <= wdata[7:0];
            end else if (sel_d) begin
                if (xidx_q == XI_DATA)
                    data_q <= wdata[LANE +: 8];
                else if (xidx_q == XI_CTRL)
                    ctrl_q <= ctrl_t'(wdata[7:0] & CTRL_MASK);
            end
        end
    end

    // strobe active while the selected read or write pulse is low
    always_comb begin
        strb_act = sel_ext && ((ctrl_q.wr_en && dat_wr) ||
                               (ctrl_q.rd_en && dat_rd));
    end

    // read mux for this socket's window
    always_comb begin
        rdata = '0;
        if (dat_rd) begin
            if (sel_x) begin
                rdata[7:0] = xidx_q;
            end else if (sel_d) begin
                if (xidx_q == XI_DATA)
                    rdata[LANE +: 8] = (ctrl_q.rd_en && !ctrl_q.wr_en) ? ext_in : data_q;
                else if (xidx_q == XI_CTRL)
                    rdata[7:0] = ctrl_q;
            end
        end
    end

    // expose control and shadow for the top
    always_comb begin
        ctrl_o = ctrl_q;
        data_o = data_q;
    end

    xds_pin u_pin (
        .act       (strb_act),
        .pol_hi    (ctrl_q.pol_hi),
        .mode_en   (ctrl_q.wr_en | ctrl_q.rd_en),
        .push_pull (ctrl_q.push_pull),
        .pu_off    (pu_off),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pin_pu    (pin_pu)
    );
endmodule

// File: rtl/xdata_strobe_port.sv
// Module: top of the indexed strobe data port. Holds the index register,
// decodes the two host ports and instantiates one slice per socket.
// Assumes an address-decoded host with active-low read/write pulses.
module xdata_strobe_port
    import xds_pkg::*;
#(
    parameter int              NSOCK    = 2,
    parameter int              DBUS_W   = 16,
    parameter int              ADDR_W   = 10,
    parameter logic [ADDR_W-1:0] IDX_PORT = 10'h3E0,
    parameter logic [ADDR_W-1:0] DAT_PORT = 10'h3E1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic [DBUS_W-1:0]   io_wdata,
    input  logic                iow_n,
    input  logic                ior_n,
    output logic [DBUS_W-1:0]   io_rdata,
    input  logic [NSOCK*8-1:0]  ext_rdata,
    input  logic [NSOCK-1:0]    pu_off,
    output logic [NSOCK-1:0]    strb_out,
    output logic [NSOCK-1:0]    strb_oe,
    output logic [NSOCK-1:0]    strb_pu
);
    logic [7:0]                   idx_q;
    logic                         idx_wr, idx_rd, dat_wr, dat_rd;
    logic [NSOCK-1:0][DBUS_W-1:0] sk_rdata;
    logic [NSOCK-1:0][7:0]        sk_ctrl;
    logic [NSOCK-1:0][7:0]        sk_data;
    logic [NSOCK-1:0]             sk_act;

    // host port decode
    always_comb begin
        idx_wr = !iow_n && (io_addr == IDX_PORT);
        idx_rd = !ior_n && (io_addr == IDX_PORT);
        dat_wr = !iow_n && (io_addr == DAT_PORT);
        dat_rd = !ior_n && (io_addr == DAT_PORT);
    end

    // index register
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (idx_wr)
            idx_q <= io_wdata[7:0];
    end

    for (genvar s = 0; s < NSOCK; s++) begin : g_sock
        xds_sock #(
            .SOCK   (s),
            .DBUS_W (DBUS_W)
        ) u_sock (
            .clk      (clk),
            .rst_n    (rst_n),
            .dat_wr   (dat_wr),
            .dat_rd   (dat_rd),
            .idx_q    (idx_q),
            .wdata    (io_wdata),
            .ext_in   (ext_rdata[s*8 +: 8]),
            .pu_off   (pu_off[s]),
            .rdata    (sk_rdata[s]),
            .strb_act (sk_act[s]),
            .ctrl_o   (sk_ctrl[s]),
            .data_o   (sk_data[s]),
            .pin_out  (strb_out[s]),
            .pin_oe   (strb_oe[s]),
            .pin_pu   (strb_pu[s])
        );
    end

    // merge read data from index port and socket windows
    always_comb begin
        io_rdata = '0;
        if (idx_rd)
            io_rdata[7:0] = idx_q;
        for (int s = 0; s < NSOCK; s++)
            io_rdata = io_rdata | sk_rdata[s];
    end
endmodule

// File: rtl/xds_chk.sv
// Module: assertion checker for xdata_strobe_port, attached by bind.
// Assumes it sees the top's index, per-socket control/shadow and strobe state.
module xds_chk #(
    parameter int                NSOCK    = 2,
    parameter int                DBUS_W   = 16,
    parameter int                ADDR_W   = 10,
    parameter logic [ADDR_W-1:0] IDX_PORT = 10'h3E0,
    parameter logic [ADDR_W-1:0] DAT_PORT = 10'h3E1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     io_addr,
    input logic [DBUS_W-1:0]     io_wdata,
    input logic                  iow_n,
    input logic                  ior_n,
    input logic [7:0]            idx_q,
    input logic [NSOCK-1:0]      sk_act,
    input logic [NSOCK-1:0][7:0] sk_ctrl,
    input logic [NSOCK-1:0][7:0] sk_data,
    input logic [NSOCK-1:0]      strb_out,
    input logic [NSOCK-1:0]      strb_oe,
    input logic [NSOCK-1:0]      strb_pu
);
    // R2
    idx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!iow_n && io_addr == IDX_PORT) |=> (idx_q == $past(io_wdata[7:0])));

    for (genvar s = 0; s < NSOCK; s++) begin : g_chk
        // R7
        strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sk_act[s] |-> (io_addr == DAT_PORT && (!iow_n || !ior_n) &&
                           idx_q == 8'(s * 64 + 8'h2F)));
        // R9
        od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !sk_ctrl[s][2] |-> !strb_out[s]);
        // R10
        pu_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(strb_pu[s] && strb_oe[s]));
        // R11
        data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            iow_n |=> $stable(sk_data[s]));
    end
endmodule

bind xdata_strobe_port xds_chk #(
    .NSOCK    (NSOCK),
    .DBUS_W   (DBUS_W),
    .ADDR_W   (ADDR_W),
    .IDX_PORT (IDX_PORT),
    .DAT_PORT (DAT_PORT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .iow_n    (iow_n),
    .ior_n    (ior_n),
    .idx_q    (idx_q),
    .sk_act   (sk_act),
    .sk_ctrl  (sk_ctrl),
    .sk_data  (sk_data),
    .strb_out (strb_out),
    .strb_oe  (strb_oe),
    .strb_pu  (strb_pu)
);

// File: tb/xdata_strobe_port_bench.sv
module xdata_strobe_port_bench;
    localparam logic [9:0] IDX = 10'h3E0;
    localparam logic [9:0] DAT = 10'h3E1;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [9:0]  io_addr = '0;
    logic [15:0] io_wdata = '0;
    logic        iow_n = 1, ior_n = 1;
    logic [15:0] io_rdata;
    logic [15:0] ext_rdata = 16'h7EC3;
    logic [1:0]  pu_off = '0;
    logic [1:0]  strb_out, strb_oe, strb_pu;

    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    xdata_strobe_port u_xdata_strobe_port (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .iow_n(iow_n), .ior_n(ior_n), .io_rdata(io_rdata),
        .ext_rdata(ext_rdata), .pu_off(pu_off),
        .strb_out(strb_out), .strb_oe(strb_oe), .strb_pu(strb_pu));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit [7:0] m_idx;
    bit [7:0] m_x[2], m_c[2], m_d[2];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx = 0;
            for (int s = 0; s < 2; s++) begin m_x[s] = 0; m_c[s] = 0; m_d[s] = 0; end
        end else if (!iow_n) begin
            if (io_addr == IDX) m_idx = io_wdata[7:0];
            else if (io_addr == DAT)
                for (int s = 0; s < 2; s++) begin
                    if (m_idx == s*64 + 46) m_x[s] = io_wdata[7:0];
                    else if (m_idx == s*64 + 47) begin
                        if (m_x[s] == 10) m_d[s] = io_wdata[15:8];
                        else if (m_x[s] == 12) m_c[s] = io_wdata[7:0] & 8'h3C;
                    end
                end
        end
    end

    logic [15:0] e_rd;
    logic [1:0]  e_out, e_oe, e_pu;

    always @(negedge clk) begin
        if (rst_n) begin
            e_rd = 0;
            if (!ior_n && io_addr == IDX) e_rd = {8'h00, m_idx};
            for (int s = 0; s < 2; s++) begin
                bit act, mode, lvl, pp;
                if (!ior_n && io_addr == DAT) begin
                    if (m_idx == s*64 + 46) e_rd = {8'h00, m_x[s]};
                    else if (m_idx == s*64 + 47) begin
                        if (m_x[s] == 10)
                            e_rd = {(m_c[s][3] && !m_c[s][4]) ? ext_rdata[s*8 +: 8] : m_d[s], 8'h00};
                        else if (m_x[s] == 12) e_rd = {8'h00, m_c[s]};
                    end
                end
                act  = (m_idx == s*64 + 47) && (m_x[s] == 10) && (io_addr == DAT) &&
                       ((m_c[s][4] && !iow_n) || (m_c[s][3] && !ior_n));
                mode = m_c[s][4] || m_c[s][3];
                pp   = m_c[s][2];
                lvl  = m_c[s][5] ? act : !act;
                e_oe[s]  = mode && (pp || !lvl);
                e_out[s] = mode && pp && lvl;
                e_pu[s]  = !mode && !pu_off[s];
            end
            chk("R2/R3/R4/R11/R12 rdata model", io_rdata, e_rd);
            chk("R5/R6/R8/R9 pin model", {strb_oe, strb_out}, {e_oe, e_out});
            chk("R10 pull-up model", strb_pu, e_pu);
        end
    end

    task automatic start_wr(input logic [9:0] a, input logic [15:0] d);
        @(posedge clk); #1; io_addr = a; io_wdata = d; iow_n = 0;
    endtask
    task automatic start_rd(input logic [9:0] a);
        @(posedge clk); #1; io_addr = a; ior_n = 0;
    endtask
    task automatic stop();
        @(posedge clk); #1; iow_n = 1; ior_n = 1;
    endtask
    task automatic io_wr(input logic [9:0] a, input logic [15:0] d);
        start_wr(a, d); stop();
    endtask
    task automatic rd_chk(input logic [9:0] a, input string tag, input logic [15:0] exp);
        start_rd(a); @(negedge clk); chk(tag, io_rdata, exp); stop();
    endtask
    task automatic set_ctrl(input int s, input logic [7:0] v);
        io_wr(IDX, 16'(s*64 + 46)); io_wr(DAT, 16'h000C);
        io_wr(IDX, 16'(s*64 + 47)); io_wr(DAT, {8'h00, v});
        io_wr(IDX, 16'(s*64 + 46)); io_wr(DAT, 16'h000A);
        io_wr(IDX, 16'(s*64 + 47));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1 oe after reset", strb_oe, 2'b00);
        chk("R1 out after reset", strb_out, 2'b00);
        chk("R1 pull-up after reset", strb_pu, 2'b11);
        rd_chk(IDX, "R1 index after reset", 16'h0000);

        io_wr(IDX, 16'h005A);
        rd_chk(IDX, "R2 index readback", 16'h005A);
        io_wr(IDX, 16'hFF2E);
        rd_chk(IDX, "R2 upper byte ignored", 16'h002E);

        io_wr(DAT, 16'h000C);
        rd_chk(DAT, "R3 extended index readback", 16'h000C);

        io_wr(IDX, 16'h002F);
        io_wr(DAT, 16'h00D3);
        rd_chk(DAT, "R4 reserved bits read 0", 16'h0010);

        io_wr(IDX, 16'h002E); io_wr(DAT, 16'h000A); io_wr(IDX, 16'h002F);
        @(negedge clk);
        chk("R10 pull-up off in strobe mode", strb_pu, 2'b10);
        start_rd(DAT); @(negedge clk);
        chk("R11 shadow resets to 0", io_rdata, 16'h0000);
        chk("R7 read ignored in write-only mode", strb_oe, 2'b00);
        stop();

        start_wr(DAT, 16'hA55A); @(negedge clk);
        chk("R5 write strobe asserts socket A only", strb_oe, 2'b01);
        chk("R9 open-drain drives 0", strb_out, 2'b00);
        stop(); @(negedge clk);
        chk("R5 strobe released after pulse", strb_oe, 2'b00);
        rd_chk(DAT, "R12 shadow on upper lane", 16'hA500);

        set_ctrl(0, 8'h38);
        @(negedge clk);
        chk("R8 active-high idles low (oe)", strb_oe[0], 1'b1);
        chk("R8 active-high idles low (out)", strb_out[0], 1'b0);
        start_rd(DAT); @(negedge clk);
        chk("R8 active-high releases when active", strb_oe[0], 1'b0);
        chk("R11 shadow wins when write mode set", io_rdata, 16'hA500);
        stop();

        set_ctrl(0, 8'h0C);
        @(negedge clk);
        chk("R9 push-pull drives high idle", {strb_oe[0], strb_out[0]}, 2'b11);
        start_rd(DAT); @(negedge clk);
        chk("R6 read strobe low while ior_n low", {strb_oe[0], strb_out[0]}, 2'b10);
        chk("R11 read-only mode returns external data", io_rdata, 16'hC300);
        stop();
        start_wr(DAT, 16'h1100); @(negedge clk);
        chk("R7 write ignored in read-only mode", strb_out[0], 1'b1);
        stop();

        io_wr(IDX, 16'h002E);
        start_rd(DAT); @(negedge clk);
        chk("R7 no strobe on wrong index", strb_out[0], 1'b1);
        chk("R3 extended index read", io_rdata, 16'h000A);
        stop();

        pu_off = 2'b10; @(negedge clk);
        chk("R10 pull-up disabled by pu_off", strb_pu, 2'b00);
        pu_off = 2'b00; @(negedge clk);
        chk("R10 pull-up restored", strb_pu, 2'b10);

        set_ctrl(1, 8'h14);
        @(negedge clk);
        chk("R10 socket B pull-up off", strb_pu, 2'b00);
        start_wr(DAT, 16'h3C00); @(negedge clk);
        chk("R5 socket B strobe only", strb_out, 2'b01);
        chk("R5 both pins driven", strb_oe, 2'b11);
        stop();
        rd_chk(DAT, "R11 socket B shadow", 16'h3C00);

        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule